// File: doc/BRIEF.md
# Bounded Hardware Stack Pointer

This block holds the stack pointer of a small microcontroller whose stack occupies a fixed 32-address window of on-chip RAM. The pointer is 11 bits wide. Only its five low bits are stored. The upper six bits are tied so that the pointer always falls between 0x60 and 0x7F. A hardware reset or a reset-stack-pointer command places the pointer at 0x7E.

Single-byte push and pull strobes move one byte. A push writes at the current pointer and then moves it down. A pull first moves the pointer up and then reads at the new position. The instruction sequencer can also ask for a whole frame. The four frame kinds are a subroutine call, a subroutine return, an interrupt entry and an interrupt return. For each requested frame the block issues one stack access per cycle. With every access it drives the RAM address, the direction, and a select code that names which register byte moves. The RAM, the register file and vector fetch are outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: `sp_o` bits 10:5 always equal 0b000011, so the pointer stays within 0x60..0x7F.
- R2: While `rst_ni` is low, `sp_o` is 0x7E, `busy_o` is 0 and `acc_o` is 0.
- R3: `rsp_i` overrides every other input. It loads 0x7E at the next edge, aborts any frame in progress and suppresses access in its own cycle.
- R4: An idle-cycle push sets `acc_o`=1 and `wr_o`=1 with `addr_o` equal to `sp_o`, and the pointer moves down by one at the next edge.
- R5: An idle-cycle pull sets `acc_o`=1 and `wr_o`=0 with `addr_o` equal to `sp_o`+1 (wrapped), and the pointer takes that value at the next edge.
- R6: Pointer arithmetic wraps inside the window. Moving down from 0x60 gives 0x7F, and moving up from 0x7F gives 0x60.
- R7: When `push_i` and `pull_i` are both high in an idle cycle, only the push is performed.
- R8: A `frame_req_i` seen while idle produces no access in that cycle. Its accesses follow on consecutive cycles starting at the next one, and `busy_o` is high exactly during those cycles. While busy and in the request cycle, push, pull and further frame requests are ignored.
- R9: Frame kind 2'b00 (call) produces two writes, with `sel_o` 0 (return PC low) and then 1 (return PC high).
- R10: Frame kind 2'b01 (subroutine return) produces two reads, with `sel_o` 1 and then 0.
- R11: Frame kind 2'b10 (interrupt entry) produces five writes, with `sel_o` 0, 1, 2, 3, 4 for PC low, PC high, X, A and CC.
- R12: Frame kind 2'b11 (interrupt return) produces five reads, with `sel_o` 4, 3, 2, 1, 0.
- R13: A single-byte push or pull drives `sel_o` = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rsp_i | input | 1 | Reset-stack-pointer command |
| push_i | input | 1 | Single-byte push strobe |
| pull_i | input | 1 | Single-byte pull strobe |
| frame_req_i | input | 1 | Start a multi-byte frame |
| frame_kind_i | input | 2 | Frame kind: 0 call, 1 return, 2 interrupt entry, 3 interrupt return |
| acc_o | output | 1 | A stack byte access happens this cycle |
| wr_o | output | 1 | Access direction: 1 write (push), 0 read (pull) |
| addr_o | output | 11 | RAM address of the access |
| sel_o | output | 3 | Register byte moved by the access |
| busy_o | output | 1 | A frame is in progress |
| sp_o | output | 11 | Current stack pointer |

## Verification
The bench first runs isolated pushes and pulls. These separate the write-then-move order from the move-then-read order, because the access address differs by one between them. It then runs each of the four frame kinds while push is held high and extra requests are made. This shows the byte order of each kind and that competing strobes are ignored. Long push runs from 0x7E walk the pointer across 0x60 to show the wrap in both directions. A reset-pointer command and an asynchronous reset, each issued in the middle of an interrupt frame, show that both abort the frame cleanly.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    FK_CALL = 2'b00,
    FK_RET  = 2'b01,
    FK_IENT = 2'b10,
    FK_IRET = 2'b11
  } frame_kind_e;

  localparam int unsigned SEL_W      = 3;
  localparam int unsigned STEP_W     = 3;
  localparam int unsigned CALL_BYTES = 2;
  localparam int unsigned INT_BYTES  = 5;

  localparam logic [SEL_W-1:0] SEL_PCL  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PCH  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_X    = 3'd2;
  localparam logic [SEL_W-1:0] SEL_A    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CC   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd7;

  function automatic logic kind_is_push(frame_kind_e k);
    return (k == FK_CALL) || (k == FK_IENT);
  endfunction

  function automatic logic [STEP_W-1:0] kind_len(frame_kind_e k);
    if (k == FK_IENT || k == FK_IRET) return STEP_W'(INT_BYTES);
    return STEP_W'(CALL_BYTES);
  endfunction
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int unsigned     PTR_W    = 11,
  parameter int unsigned     WIN_W    = 5,
  parameter logic [PTR_W-1:0] WIN_BASE = 11'h060,
  parameter logic [PTR_W-1:0] RSP_VAL  = 11'h07E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] sp_up_o
);
  localparam int unsigned HI_W = PTR_W - WIN_W;
  localparam logic [HI_W-1:0] HI_BITS = WIN_BASE[PTR_W-1:WIN_W];
  localparam logic [WIN_W-1:0] LOW_RST = RSP_VAL[WIN_W-1:0];

  logic [WIN_W-1:0] low_q;
  logic [WIN_W-1:0] low_up, low_dn;

  // only the low window bits move; wrap is natural modulo 2**WIN_W
  assign low_up = low_q + 1'b1;
  assign low_dn = low_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_q <= LOW_RST;
    else if (load_i) low_q <= LOW_RST;
    else if (dec_i)  low_q <= low_dn;
    else if (inc_i)  low_q <= low_up;
  end

  assign sp_o    = {HI_BITS, low_q};
  assign sp_up_o = {HI_BITS, low_up};
endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
  import stk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  frame_kind_e       kind_i,
  output logic              active_o,
  output frame_kind_e       kind_o,
  output logic [STEP_W-1:0] step_o
);
  logic              active_q;
  frame_kind_e       kind_q;
  logic [STEP_W-1:0] step_q;
  logic              last;

  assign last = (step_q == kind_len(kind_q) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= FK_CALL;
      step_q   <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (active_q) begin
      if (last) begin
        active_q <= 1'b0;
        step_q   <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      kind_q   <= kind_i;
      step_q   <= '0;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;
  assign step_o   = step_q;
endmodule

// File: rtl/stk_sel_map.sv
module stk_sel_map
  import stk_pkg::*;
(
  input  frame_kind_e       kind_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              wr_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [STEP_W-1:0] len;

  assign len  = kind_len(kind_i);
  assign wr_o = kind_is_push(kind_i);

  // pushes go PCL upward, pulls mirror the order from the top of the frame
  always_comb begin
    if (wr_o) sel_o = SEL_W'(step_i);
    else      sel_o = SEL_W'(len - 1'b1 - step_i);
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stk_pkg::*;
#(
  parameter int unsigned      PTR_W    = 11,
  parameter int unsigned      WIN_W    = 5,
  parameter logic [PTR_W-1:0] WIN_BASE = 11'h060,
  parameter logic [PTR_W-1:0] RSP_VAL  = 11'h07E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsp_i,
  input  logic             push_i,
  input  logic             pull_i,
  input  logic             frame_req_i,
  input  logic [1:0]       frame_kind_i,
  output logic             acc_o,
  output logic             wr_o,
  output logic [PTR_W-1:0] addr_o,
  output logic [2:0]       sel_o,
  output logic             busy_o,
  output logic [PTR_W-1:0] sp_o
);
  logic              active;
  frame_kind_e       kind;
  logic [STEP_W-1:0] step;
  logic              map_wr;
  logic [SEL_W-1:0]  map_sel;
  logic [PTR_W-1:0]  sp, sp_up;
  logic              frame_acc, idle_ok, do_push, do_pull, start;

  assign frame_acc = active && !rsp_i;
  assign idle_ok   = !active && !rsp_i && !frame_req_i;
  assign do_push   = idle_ok && push_i;
  assign do_pull   = idle_ok && pull_i && !push_i;
  assign start     = !active && !rsp_i && frame_req_i;

  stk_frame_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (rsp_i),
    .start_i  (start),
    .kind_i   (frame_kind_e'(frame_kind_i)),
    .active_o (active),
    .kind_o   (kind),
    .step_o   (step)
  );

  stk_sel_map u_map (
    .kind_i (kind),
    .step_i (step),
    .wr_o   (map_wr),
    .sel_o  (map_sel)
  );

  stk_ptr_reg #(
    .PTR_W    (PTR_W),
    .WIN_W    (WIN_W),
    .WIN_BASE (WIN_BASE),
    .RSP_VAL  (RSP_VAL)
  ) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rsp_i),
    .dec_i   (acc_o && wr_o),
    .inc_i   (acc_o && !wr_o),
    .sp_o    (sp),
    .sp_up_o (sp_up)
  );

  assign acc_o  = frame_acc || do_push || do_pull;
  assign wr_o   = frame_acc ? map_wr : do_push;
  assign sel_o  = frame_acc ? map_sel : SEL_DATA;
  assign addr_o = (acc_o && !wr_o) ? sp_up : sp;
  assign busy_o = active;
  assign sp_o   = sp;
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int unsigned      PTR_W    = 11,
  parameter int unsigned      WIN_W    = 5,
  parameter logic [PTR_W-1:0] WIN_BASE = 11'h060,
  parameter logic [PTR_W-1:0] RSP_VAL  = 11'h07E
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rsp_i,
  input logic             push_i,
  input logic             pull_i,
  input logic             acc_o,
  input logic             wr_o,
  input logic [PTR_W-1:0] addr_o,
  input logic [2:0]       sel_o,
  input logic             busy_o,
  input logic [PTR_W-1:0] sp_o
);
  logic [PTR_W-1:0] sp_dn, sp_up;
  assign sp_dn = {sp_o[PTR_W-1:WIN_W], sp_o[WIN_W-1:0] - 1'b1};
  assign sp_up = {sp_o[PTR_W-1:WIN_W], sp_o[WIN_W-1:0] + 1'b1};

  a_r1_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o[PTR_W-1:WIN_W] == WIN_BASE[PTR_W-1:WIN_W]);

  a_r3_rsp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_i |=> sp_o == RSP_VAL);

  a_r3_rsp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_i |-> !acc_o);

  a_r4_push_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && wr_o |-> addr_o == sp_o);

  a_r4_push_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && wr_o |=> sp_o == $past(sp_dn));

  a_r5_pull_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && !wr_o |-> addr_o == sp_up);

  a_r5_pull_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && !wr_o |=> sp_o == $past(sp_up));

  a_r8_busy_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rsp_i |-> acc_o && sel_o != 3'd7);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !push_i && !pull_i |-> !acc_o);

  a_r13_single_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && acc_o |-> sel_o == 3'd7);
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
  .PTR_W    (PTR_W),
  .WIN_W    (WIN_W),
  .WIN_BASE (WIN_BASE),
  .RSP_VAL  (RSP_VAL)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rsp_i  (rsp_i),
  .push_i (push_i),
  .pull_i (pull_i),
  .acc_o  (acc_o),
  .wr_o   (wr_o),
  .addr_o (addr_o),
  .sel_o  (sel_o),
  .busy_o (busy_o),
  .sp_o   (sp_o)
);

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rsp_i = 1'b0, push_i = 1'b0, pull_i = 1'b0, frame_req_i = 1'b0;
  logic [1:0]  frame_kind_i = 2'b00;
  logic        acc_o, wr_o, busy_o;
  logic [10:0] addr_o, sp_o;
  logic [2:0]  sel_o;

  always #5 clk_i = ~clk_i;

  stack_ptr_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rsp_i(rsp_i), .push_i(push_i),
    .pull_i(pull_i), .frame_req_i(frame_req_i), .frame_kind_i(frame_kind_i),
    .acc_o(acc_o), .wr_o(wr_o), .addr_o(addr_o), .sel_o(sel_o),
    .busy_o(busy_o), .sp_o(sp_o)
  );

  typedef struct { bit wr; int sel; string tag; } op_t;
  op_t q[$];
  int  m_sp;
  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  function automatic int dn(int s); return 'h60 + ((s - 'h60 - 1) & 31); endfunction
  function automatic int up(int s); return 'h60 + ((s - 'h60 + 1) & 31); endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic add(bit wr, int sel, string tag);
    op_t o; o.wr = wr; o.sel = sel; o.tag = tag; q.push_back(o);
  endtask

  task automatic enqueue(int kind);
    case (kind)
      0: begin add(1, 0, "R9");  add(1, 1, "R9");  end          // R9 call
      1: begin add(0, 1, "R10"); add(0, 0, "R10"); end          // R10 return
      2: for (int i = 0; i < 5; i++) add(1, i, "R11");          // R11 entry
      default: for (int i = 4; i >= 0; i--) add(0, i, "R12");   // R12 int return
    endcase
  endtask

  task automatic cyc(bit rsp, bit psh, bit pll, bit req, int kind);
    bit e_acc, e_wr, e_busy; int e_addr, e_sel; string tag;
    @(negedge clk_i);
    rsp_i = rsp; push_i = psh; pull_i = pll; frame_req_i = req;
    frame_kind_i = 2'(kind);
    #2;
    e_busy = q.size() > 0; e_acc = 0; e_wr = 0; e_addr = 0; e_sel = 7;
    if (rsp) tag = "R3";
    else if (q.size() > 0) begin
      e_acc = 1; e_wr = q[0].wr; e_sel = q[0].sel;
      e_addr = e_wr ? m_sp : up(m_sp); tag = q[0].tag;
    end else if (req) tag = "R8";
    else if (psh) begin e_acc = 1; e_wr = 1; e_addr = m_sp; tag = pll ? "R7" : "R4"; end
    else if (pll) begin e_acc = 1; e_wr = 0; e_addr = up(m_sp); tag = "R5"; end
    else tag = "R8";
    chk(acc_o == e_acc, tag, "acc", acc_o, e_acc);
    if (e_acc) begin
      chk(wr_o == e_wr, tag, "wr", wr_o, e_wr);
      chk(addr_o == 11'(e_addr), tag, "addr", addr_o, e_addr);
      chk(sel_o == 3'(e_sel), e_busy ? tag : "R13", "sel", sel_o, e_sel);
    end
    chk(busy_o == e_busy, "R8", "busy", busy_o, e_busy);
    chk(sp_o == 11'(m_sp), tag, "sp", sp_o, m_sp);
    chk(sp_o[10:5] == 6'b000011, "R1", "window", sp_o, 'h60);
    @(posedge clk_i);
    if (rsp) begin m_sp = 'h7E; q.delete(); end
    else if (q.size() > 0) begin m_sp = q[0].wr ? dn(m_sp) : up(m_sp); void'(q.pop_front()); end
    else if (req) enqueue(kind);
    else if (psh) m_sp = dn(m_sp);
    else if (pll) m_sp = up(m_sp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic reset_check();
    @(negedge clk_i);
    rst_ni = 1'b0; rsp_i = 0; push_i = 0; pull_i = 0; frame_req_i = 0;
    #2;
    chk(sp_o == 11'h07E, "R2", "sp", sp_o, 'h7E);
    chk(busy_o == 1'b0, "R2", "busy", busy_o, 0);
    chk(acc_o == 1'b0, "R2", "acc", acc_o, 0);
    m_sp = 'h7E; q.delete();
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    m_sp = 'h7E;
    reset_check();
    // single pushes then pulls
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    // R7 both strobes
    cyc(0, 1, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    // each frame kind, push held high and repeated requests while busy
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 1, k);
      for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1, (k + 1) % 4);
      cyc(0, 0, 0, 0, 0);
    end
    // R6 wrap: 0x7E down to 0x60 then past
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 31; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    // interrupt entry crossing the wrap
    cyc(0, 0, 0, 1, 2);
    idle(6);
    cyc(0, 0, 0, 1, 3);
    idle(6);
    // R3 mid-frame abort
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 2);
    idle(3);
    // R2 async reset mid-frame
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 0, 0);
    reset_check();
    idle(3);
    cyc(0, 0, 1, 0, 0);
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule